// File: doc/BRIEF.md
# Universal Shift/Storage Register with Shared Parallel Port

This block is a parameterised (default 8-bit) storage register. On each clock edge it can keep its contents, move them one place toward the high bit, move them one place toward the low bit, or take a new word in parallel. Parallel data enters and leaves on one shared bidirectional pin per bit. At the block boundary each pin appears as three signals: an incoming value, an outgoing value and a drive enable. The pad ring at chip level joins these three into the tri-state pin.

A two-bit select input chooses the operation. An active-low clear zeroes the register on a clock edge. Two active-low output enables gate the pin drivers. Load mode also turns the drivers off, so that an external source can put a word onto the shared pins. The end bits are always available on dedicated serial outputs, and there are serial inputs at both ends. Several instances can therefore be chained into a longer word, and the chain keeps working while the parallel pins are released.

Top module: `usr_bidir_shift`

## Requirements
- R1: While `rst` is high at a clock edge the register becomes all zeros, and `pin_out` reads 0 after that edge.
- R2: With `sel` = 2'b00 (hold) and `clr_n` high, the register keeps its value across the edge.
- R3: With `sel` = 2'b01 (shift toward the high bit) and `clr_n` high, the next value is {q[WIDTH-2:0], `ser_r_in`}. `ser_r_in` enters bit 0.
- R4: With `sel` = 2'b10 (shift toward the low bit) and `clr_n` high, the next value is {`ser_l_in`, q[WIDTH-1:1]}. `ser_l_in` enters bit WIDTH-1.
- R5: With `sel` = 2'b11 (load) and `clr_n` high, the register captures `pin_in` at the edge.
- R6: `clr_n` low at a clock edge zeroes the register whatever `sel` selects. Clear takes priority over load and both shifts.
- R7: Every bit of `pin_drv` is 1 exactly when `oe1_n` and `oe2_n` are both low and `sel` is not 2'b11. Otherwise every bit is 0. It follows these inputs in the same cycle, with no clock edge needed.
- R8: The output enables have no effect on clearing, shifting, holding or loading. The register keeps updating while the pins are released.
- R9: `q_lsb` always equals register bit 0 and `q_msb` always equals bit WIDTH-1, in every output-enable state. `pin_out` always carries the full register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Synchronous clear, active low |
| sel | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| oe1_n | input | 1 | Output enable 1, active low |
| oe2_n | input | 1 | Output enable 2, active low |
| ser_r_in | input | 1 | Serial bit that enters bit 0 during shift up |
| ser_l_in | input | 1 | Serial bit that enters the top bit during shift down |
| pin_in | input | WIDTH | Value seen on the shared pins |
| pin_out | output | WIDTH | Register value offered to the shared pins |
| pin_drv | output | WIDTH | Per-bit pin drive enable |
| q_lsb | output | 1 | Register bit 0, always driven |
| q_msb | output | 1 | Register top bit, always driven |

## Verification
`pin_drv` is a combinational function of `sel` and the two enables, so it is checked in the same cycle, a few nanoseconds after those inputs change and well before the next edge. The register, `pin_out` and both serial outputs change at the first rising edge after the inputs are applied. The bench computes the expected next state from the inputs it applied before that edge. It samples these outputs 2 ns after the edge, before it drives new inputs. Random cycles mix all four select codes with enable and clear changes. Directed cases cover load with clear, shifting while the pins are released, and all four enable combinations.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec #(
  parameter int WIDTH = 8
) (
  input  logic [1:0]         sel,
  input  logic               oe1_n,
  input  logic               oe2_n,
  output usr_pkg::mode_e     mode,
  output logic [WIDTH-1:0]   drv
);
  logic load_sel;
  logic port_on;

  always_comb begin
    mode     = usr_pkg::mode_e'(sel);
    load_sel = (mode == usr_pkg::MODE_LOAD);
    // load releases the pins so an outside source can present data
    port_on  = !oe1_n && !oe2_n && !load_sel;
    drv      = {WIDTH{port_on}};
  end
endmodule

// File: rtl/usr_cell.sv
module usr_cell (
  input  usr_pkg::mode_e mode,
  input  logic           cur,
  input  logic           from_lo,
  input  logic           from_hi,
  input  logic           par,
  output logic           nxt
);
  always_comb begin
    unique case (mode)
      usr_pkg::MODE_HOLD: nxt = cur;
      usr_pkg::MODE_UP:   nxt = from_lo;
      usr_pkg::MODE_DOWN: nxt = from_hi;
      default:            nxt = par;
    endcase
  end
endmodule

// File: rtl/usr_bidir_shift.sv
module usr_bidir_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic [1:0]       sel,
  input  logic             oe1_n,
  input  logic             oe2_n,
  input  logic             ser_r_in,
  input  logic             ser_l_in,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_drv,
  output logic             q_lsb,
  output logic             q_msb
);
  localparam int MSB = WIDTH - 1;

  usr_pkg::mode_e mode;
  logic [MSB:0]   q;
  logic [MSB:0]   q_nxt;
  logic [MSB:0]   nb_lo;
  logic [MSB:0]   nb_hi;

  usr_mode_dec #(.WIDTH(WIDTH)) u_dec (
    .sel   (sel),
    .oe1_n (oe1_n),
    .oe2_n (oe2_n),
    .mode  (mode),
    .drv   (pin_drv)
  );

  // neighbour feeding each bit for either shift direction
  assign nb_lo = {q[MSB-1:0], ser_r_in};
  assign nb_hi = {ser_l_in, q[MSB:1]};

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    usr_cell u_cell (
      .mode    (mode),
      .cur     (q[i]),
      .from_lo (nb_lo[i]),
      .from_hi (nb_hi[i]),
      .par     (pin_in[i]),
      .nxt     (q_nxt[i])
    );
  end

  // clear outranks every mode; output enables play no part here
  always_ff @(posedge clk) begin
    if (rst || !clr_n) q <= '0;
    else               q <= q_nxt;
  end

  assign pin_out = q;
  assign q_lsb   = q[0];
  assign q_msb   = q[MSB];

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (q == '0));

  a_r2_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    (clr_n && sel == 2'b00) |=> $stable(q));

  a_r3_shift_up: assert property (@(posedge clk) disable iff (rst)
    (clr_n && sel == 2'b01) |=> (q == {$past(q[MSB-1:0]), $past(ser_r_in)}));

  a_r4_shift_down: assert property (@(posedge clk) disable iff (rst)
    (clr_n && sel == 2'b10) |=> (q == {$past(ser_l_in), $past(q[MSB:1])}));

  a_r5_load_capture: assert property (@(posedge clk) disable iff (rst)
    (clr_n && sel == 2'b11) |=> (q == $past(pin_in)));

  a_r7_load_releases: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b11 || oe1_n || oe2_n) |-> (pin_drv == '0));
endmodule

// File: tb/tb_usr_bidir_shift.sv
module tb_usr_bidir_shift;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr_n = 1'b1;
  logic [1:0]   sel = 2'b00;
  logic         oe1_n = 1'b0;
  logic         oe2_n = 1'b0;
  logic         ser_r_in = 1'b0;
  logic         ser_l_in = 1'b0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out;
  logic [W-1:0] pin_drv;
  logic         q_lsb;
  logic         q_msb;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] model = '0;
  logic [W-1:0] tmp;

  usr_bidir_shift #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .sel(sel), .oe1_n(oe1_n),
    .oe2_n(oe2_n), .ser_r_in(ser_r_in), .ser_l_in(ser_l_in),
    .pin_in(pin_in), .pin_out(pin_out), .pin_drv(pin_drv),
    .q_lsb(q_lsb), .q_msb(q_msb)
  );

  always #10 clk = ~clk;

  function automatic logic [W-1:0] next_q(logic [W-1:0] q, logic [1:0] s,
      logic c_n, logic sr, logic sl, logic [W-1:0] p);
    if (!c_n) return '0;
    case (s)
      2'b00:   return q;
      2'b01:   return {q[W-2:0], sr};
      2'b10:   return {sl, q[W-1:1]};
      default: return p;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_drv(logic [1:0] s, logic a_n, logic b_n);
    return (!a_n && !b_n && s != 2'b11) ? {W{1'b1}} : {W{1'b0}};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs(string tag);
    chk({tag, " pin_out"}, 32'(pin_out), 32'(model));
    chk("R9 q_lsb", 32'(q_lsb), 32'(model[0]));
    chk("R9 q_msb", 32'(q_msb), 32'(model[W-1]));
  endtask

  // apply inputs 2ns after an edge, check pin_drv, clock once, check state
  task automatic step(string tag, logic [1:0] s, logic c_n, logic a_n,
      logic b_n, logic sr, logic sl, logic [W-1:0] p);
    sel = s; clr_n = c_n; oe1_n = a_n; oe2_n = b_n;
    ser_r_in = sr; ser_l_in = sl; pin_in = p;
    #3;
    chk("R7 pin_drv", 32'(pin_drv), 32'(exp_drv(s, a_n, b_n)));
    model = next_q(model, s, c_n, sr, sl, p);
    @(posedge clk); #2;
    check_regs(tag);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    checks++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    model = '0;
    check_regs("R1");

    // R5 load, then R2 hold
    step("R5", 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
    for (int k = 0; k < 3; k++) step("R2", 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C);
    // R3 shift up with ones entering bit 0
    for (int k = 0; k < 4; k++) step("R3", 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    // R4 shift down with zeros entering the top bit
    for (int k = 0; k < 5; k++) step("R4", 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF);
    // R6 clear beats load
    step("R5", 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81);
    step("R6", 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h7E);
    chk("R6 clear over load", 32'(pin_out), 32'h0);
    // R8 registers update while pins are released
    step("R5", 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5A);
    chk("R8 load with oe off", 32'(pin_out), 32'h5A);
    step("R8", 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    step("R8", 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R8 shift with oe off", 32'(pin_out), 32'hDA);
    step("R6", 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    chk("R6 clear with oe off", 32'(pin_out), 32'h0);
    // R7 every enable combination under each select code
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 4; e++)
        step("R7", 2'(s), 1'b1, e[0], e[1], 1'b1, 1'b0, 8'hC3);
    // R9 serial outputs while released
    step("R5", 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h81);
    chk("R9 lsb released", 32'(q_lsb), 32'h1);
    chk("R9 msb released", 32'(q_msb), 32'h1);

    // constrained random
    for (int k = 0; k < 400; k++) begin
      tmp = W'($urandom);
      step("RND", 2'($urandom_range(3, 0)), ($urandom_range(7, 0) != 0),
           ($urandom_range(3, 0) == 0), ($urandom_range(3, 0) == 0),
           1'($urandom), 1'($urandom), tmp);
    end

    // R1 reset mid-run
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0;
    model = '0;
    check_regs("R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule